// File: doc/BRIEF.md
# Exact algebraic-integer 8-point DCT core

This core computes one 8-point forward DCT per clock cycle with no rounding at all. Every number inside it is an element of a ring spanned by four basis values: 1, a = √2, b = √(2+√2) and a·b. Each number is therefore a group of four signed integer channels. Two reductions keep products inside that span: a·a = 2 and b·b = 2 + a. The transform follows a fast factorised flow graph that needs only five constant multiplications. Each of those constants has an exact encoding with entries of ±2 or 4, so every product reduces to channel swaps, wired shifts and additions.

Samples can arrive in two forms. In raw form each sample is a plain integer, which by itself is an exact encoding with the other three channels at zero. In encoded form all four channels of a sample carry data. Each coefficient leaves the core still encoded and scaled by four; the core has no decoding stage. Downstream logic, for example a second pass of the transform or a final converter to fixed point, uses the coefficients as they are. The intended use is as the column or row stage of a two-dimensional transform in which no error enters before the last stage.

Top module: `ai_dct8`

## Requirements
- R1: When `in_raw` is 1, sample n is the signed integer in `in_data[(4n)*IW +: IW]`. The other three channels of each sample are ignored.
- R2: When `in_raw` is 0, sample n is c0 + c1·√2 + c2·b + c3·√2·b with b = √(2+√2). Channel c of sample n is the signed field `in_data[(4n+c)*IW +: IW]`.
- R3: Coefficient k, channel c, is the signed field `out_data[(4k+c)*OW +: OW]`. Decoded in the same basis and divided by 4, it equals exactly F0 for k = 0 and 2·cos(kπ/16)·Fk otherwise, where Fk = Σn xn·cos((2n+1)kπ/16).
- R4: A raw input whose eight samples all equal v gives coefficient 0 = (32v, 0, 0, 0). Every channel of every other coefficient is 0.
- R5: For a raw input, channels 1 to 3 of coefficients 0 and 4 are zero.
- R6: `out_valid` repeats `in_valid` two rising edges later. The coefficients of that input are on `out_data` while the delayed flag is high.
- R7: While `rst_n` is low, `out_valid` is low. The reset acts without waiting for a clock edge.
- R8: With IW = 8 and GUARD = 10, no channel overflows. This holds for any input, including every channel at -128 or 127 in encoded form.
- R9: A new input vector is accepted on every cycle, and back-to-back vectors give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector present this cycle |
| in_raw | input | 1 | 1: plain integer samples in channel 0; 0: four-channel encoded samples |
| in_data | input | 32*IW | Eight samples of four signed channels each |
| out_valid | output | 1 | Output vector present |
| out_data | output | 32*OW | Eight coefficients of four signed channels each, scaled by 4 |

## Verification
An input presented before a rising edge is captured at that edge, and its coefficients and valid flag show up after the next rising edge. The bench drives inputs at falling edges. At each falling edge it compares the outputs against the vector it drove two falling edges earlier, so every cycle, idle or busy, checks the valid flag. Coefficients are decoded to reals and compared against a direct cosine-sum model. The structural-zero and flat-input cases are compared channel by channel as exact integers. The reset check samples one time step after `rst_n` falls, with no clock edge in between.

// File: rtl/ai_dct8.sv
module ai_dct8 #(
  parameter int IW = 8,
  parameter int GUARD = 10,
  localparam int OW = IW + GUARD,
  localparam int NPT = 8,
  localparam int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_raw,
  input  logic [NPT*NCH*IW-1:0]  in_data,
  output logic                   out_valid,
  output logic [NPT*NCH*OW-1:0]  out_data
);
  typedef logic signed [OW-1:0] ch_t;
  typedef struct packed { ch_t c3; ch_t c2; ch_t c1; ch_t c0; } ai_t;

  function automatic ai_t ai_add(ai_t p, ai_t q);
    ai_t r;
    r.c0 = p.c0 + q.c0; r.c1 = p.c1 + q.c1;
    r.c2 = p.c2 + q.c2; r.c3 = p.c3 + q.c3;
    return r;
  endfunction

  function automatic ai_t ai_sub(ai_t p, ai_t q);
    ai_t r;
    r.c0 = p.c0 - q.c0; r.c1 = p.c1 - q.c1;
    r.c2 = p.c2 - q.c2; r.c3 = p.c3 - q.c3;
    return r;
  endfunction

  function automatic ai_t ai_dbl(ai_t p);
    ai_t r;
    r.c0 = p.c0 <<< 1; r.c1 = p.c1 <<< 1;
    r.c2 = p.c2 <<< 1; r.c3 = p.c3 <<< 1;
    return r;
  endfunction

  // times sqrt2: sqrt2*sqrt2 = 2
  function automatic ai_t ai_ma(ai_t p);
    ai_t r;
    r.c0 = p.c1 <<< 1; r.c1 = p.c0;
    r.c2 = p.c3 <<< 1; r.c3 = p.c2;
    return r;
  endfunction

  // times b: b*b = 2 + sqrt2
  function automatic ai_t ai_mb(ai_t p);
    ai_t r;
    r.c0 = (p.c2 + p.c3) <<< 1;
    r.c1 = p.c2 + (p.c3 <<< 1);
    r.c2 = p.c0;
    r.c3 = p.c1;
    return r;
  endfunction

  function automatic ai_t ai_x4(ai_t p);
    return ai_dbl(ai_dbl(p));
  endfunction

  // 4*cos(pi/4) = 2*sqrt2
  function automatic ai_t k_c4(ai_t p);
    return ai_dbl(ai_ma(p));
  endfunction

  // 4*cos(3pi/8) = 2*b*(sqrt2 - 1)
  function automatic ai_t k_c6(ai_t p);
    ai_t w;
    w = ai_mb(p);
    return ai_dbl(ai_sub(ai_ma(w), w));
  endfunction

  // 4*(cos(pi/8) - cos(3pi/8)) = 2*b*(2 - sqrt2)
  function automatic ai_t k_dif(ai_t p);
    ai_t w;
    w = ai_mb(p);
    return ai_dbl(ai_sub(ai_dbl(w), ai_ma(w)));
  endfunction

  // 4*(cos(pi/8) + cos(3pi/8)) = 2*sqrt2*b
  function automatic ai_t k_sum(ai_t p);
    return ai_dbl(ai_ma(ai_mb(p)));
  endfunction

  ai_t enc [NPT];
  ai_t x_q [NPT];
  ai_t y_d [NPT];
  ai_t y_q [NPT];
  logic v_q;

  for (genvar n = 0; n < NPT; n++) begin : g_enc
    assign enc[n] = '{
      c3: in_raw ? ch_t'(0) : ch_t'($signed(in_data[(NCH*n+3)*IW +: IW])),
      c2: in_raw ? ch_t'(0) : ch_t'($signed(in_data[(NCH*n+2)*IW +: IW])),
      c1: in_raw ? ch_t'(0) : ch_t'($signed(in_data[(NCH*n+1)*IW +: IW])),
      c0: ch_t'($signed(in_data[(NCH*n)*IW +: IW]))
    };
  end

  ai_t s07, s16, s25, s34, d07, d16, d25, d34;
  ai_t e10, e11, e12, e13, m1;
  ai_t o10, o11, o12, m2, m3, m4, m5, z11, z13;

  assign s07 = ai_add(x_q[0], x_q[7]);
  assign d07 = ai_sub(x_q[0], x_q[7]);
  assign s16 = ai_add(x_q[1], x_q[6]);
  assign d16 = ai_sub(x_q[1], x_q[6]);
  assign s25 = ai_add(x_q[2], x_q[5]);
  assign d25 = ai_sub(x_q[2], x_q[5]);
  assign s34 = ai_add(x_q[3], x_q[4]);
  assign d34 = ai_sub(x_q[3], x_q[4]);

  assign e10 = ai_add(s07, s34);
  assign e13 = ai_sub(s07, s34);
  assign e11 = ai_add(s16, s25);
  assign e12 = ai_sub(s16, s25);
  assign m1  = k_c4(ai_add(e12, e13));

  assign y_d[0] = ai_x4(ai_add(e10, e11));
  assign y_d[4] = ai_x4(ai_sub(e10, e11));
  assign y_d[2] = ai_add(ai_x4(e13), m1);
  assign y_d[6] = ai_sub(ai_x4(e13), m1);

  assign o10 = ai_add(d34, d25);
  assign o11 = ai_add(d25, d16);
  assign o12 = ai_add(d16, d07);
  assign m5  = k_c6(ai_sub(o10, o12));
  assign m2  = ai_add(k_dif(o10), m5);
  assign m4  = ai_add(k_sum(o12), m5);
  assign m3  = k_c4(o11);
  assign z11 = ai_add(ai_x4(d07), m3);
  assign z13 = ai_sub(ai_x4(d07), m3);

  assign y_d[5] = ai_add(z13, m2);
  assign y_d[3] = ai_sub(z13, m2);
  assign y_d[1] = ai_add(z11, m4);
  assign y_d[7] = ai_sub(z11, m4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q       <= 1'b0;
      out_valid <= 1'b0;
      for (int i = 0; i < NPT; i++) begin
        x_q[i] <= '0;
        y_q[i] <= '0;
      end
    end else begin
      v_q       <= in_valid;
      out_valid <= v_q;
      x_q       <= enc;
      y_q       <= y_d;
    end
  end

  for (genvar k = 0; k < NPT; k++) begin : g_out
    assign out_data[k*NCH*OW +: NCH*OW] = y_q[k];
  end
endmodule

// File: rtl/ai_dct8_chk.sv
module ai_dct8_chk #(
  parameter int IW = 8,
  parameter int GUARD = 10,
  localparam int OW = IW + GUARD,
  localparam int NPT = 8,
  localparam int NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_raw,
  input logic [NPT*NCH*IW-1:0] in_data,
  input logic                  out_valid,
  input logic [NPT*NCH*OW-1:0] out_data
);
  logic [1:0] since;
  logic flat_in, zero_in, raw_in, raw_zero_ok;
  logic [OW-1:0] flat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  always_comb begin
    flat_in = in_valid && in_raw;
    for (int n = 1; n < NPT; n++)
      if (in_data[n*NCH*IW +: IW] != in_data[IW-1:0]) flat_in = 1'b0;
  end

  assign zero_in  = in_valid && (in_data == '0);
  assign raw_in   = in_valid && in_raw;
  assign flat_exp = {{(OW-IW-5){in_data[IW-1]}}, in_data[IW-1:0], 5'b0};
  assign raw_zero_ok = (out_data[NCH*OW-1:OW] == '0) &&
                       (out_data[5*NCH*OW-1 : 4*NCH*OW+OW] == '0);

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !out_valid); // R7

  AST_RAW_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2 && $past(raw_in, 2)) |-> raw_zero_ok); // R5

  AST_FLAT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2 && $past(flat_in, 2)) |->
      (out_data[OW-1:0] == $past(flat_exp, 2) &&
       out_data[NPT*NCH*OW-1:OW] == '0)); // R4

  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2 && $past(zero_in, 2)) |-> (out_valid && out_data == '0)); // R3
endmodule

bind ai_dct8 ai_dct8_chk #(.IW(IW), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/ai_dct8_test.sv
module ai_dct8_test;
  localparam int PERIOD = 10;
  localparam int IW = 8;
  localparam int GUARD = 10;
  localparam int OW = IW + GUARD;
  localparam int NPT = 8;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_raw;
  logic [NPT*NCH*IW-1:0] in_data;
  logic out_valid;
  logic [NPT*NCH*OW-1:0] out_data;

  always #(PERIOD/2) clk = ~clk;

  ai_dct8 #(.IW(IW), .GUARD(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int n_run, n_fail;
  bit done;
  real RA = $sqrt(2.0);
  real RB = $sqrt(2.0 + $sqrt(2.0));
  real PI = 3.14159265358979;

  int stim [NPT][NCH];
  bit hv [2], hraw [2], hflat [2];
  int hfv [2];
  real he [2][NPT];
  string htag [2];

  function automatic real dec(int a, int b, int c, int d);
    return a + b * RA + c * RB + d * RA * RB;
  endfunction

  task automatic check(bit ok, string req, string what, real act, real exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(out_valid == hv[1], "R6", "out_valid", out_valid, hv[1]);
    if (hv[1]) begin
      for (int k = 0; k < NPT; k++) begin
        int c [NCH];
        real a, d, e;
        for (int ch = 0; ch < NCH; ch++) c[ch] = $signed(out_data[(k*NCH+ch)*OW +: OW]);
        a = dec(c[0], c[1], c[2], c[3]) / 4.0;
        e = he[1][k];
        d = a - e;
        if (d < 0.0) d = -d;
        check(d <= 1e-6 * (1.0 + (e < 0.0 ? -e : e)), htag[1],
              $sformatf("R3 coefficient %0d", k), a, e);
        if (hraw[1] && (k == 0 || k == 4))
          for (int ch = 1; ch < NCH; ch++)
            check(c[ch] == 0, "R5", $sformatf("coef %0d chan %0d", k, ch), c[ch], 0);
        if (hflat[1])
          for (int ch = 0; ch < NCH; ch++)
            check(c[ch] == ((k == 0 && ch == 0) ? 32 * hfv[1] : 0), "R4",
                  $sformatf("coef %0d chan %0d", k, ch), c[ch],
                  (k == 0 && ch == 0) ? 32 * hfv[1] : 0);
      end
    end
  endtask

  task automatic step(bit v, bit raw, string tag);
    real x [NPT];
    bit flat;
    @(negedge clk);
    compare();
    hv[1] = hv[0]; hraw[1] = hraw[0]; hflat[1] = hflat[0];
    hfv[1] = hfv[0]; he[1] = he[0]; htag[1] = htag[0];
    flat = raw;
    for (int n = 0; n < NPT; n++) begin
      x[n] = raw ? stim[n][0] : dec(stim[n][0], stim[n][1], stim[n][2], stim[n][3]);
      if (stim[n][0] != stim[0][0]) flat = 1'b0;
    end
    for (int k = 0; k < NPT; k++) begin
      real f = 0.0;
      for (int n = 0; n < NPT; n++) f += x[n] * $cos((2 * n + 1) * k * PI / 16.0);
      he[0][k] = (k == 0) ? f : f * 2.0 * $cos(k * PI / 16.0);
    end
    hv[0] = v; hraw[0] = v && raw; hflat[0] = v && flat;
    hfv[0] = stim[0][0]; htag[0] = tag;
    in_valid = v;
    in_raw = raw;
    for (int n = 0; n < NPT; n++)
      for (int ch = 0; ch < NCH; ch++)
        in_data[(n*NCH+ch)*IW +: IW] = IW'(stim[n][ch]);
  endtask

  task automatic fill_rand(bit extreme);
    for (int n = 0; n < NPT; n++)
      for (int ch = 0; ch < NCH; ch++)
        if (extreme) stim[n][ch] = ($urandom_range(0, 1) == 1) ? 127 : -128;
        else stim[n][ch] = int'($urandom_range(0, 255)) - 128;
  endtask

  task automatic fill_const(int v);
    for (int n = 0; n < NPT; n++)
      for (int ch = 0; ch < NCH; ch++) stim[n][ch] = v;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_raw = 1'b1;
    in_data = '1;
    for (int i = 0; i < 2; i++) begin
      hv[i] = 0; hraw[i] = 0; hflat[i] = 0; hfv[i] = 0; htag[i] = "R3";
      for (int k = 0; k < NPT; k++) he[i][k] = 0.0;
    end
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    end
    rst_n = 1'b1;
    in_valid = 1'b0;

    // R3 R9: raw impulses back to back
    for (int p = 0; p < NPT; p++) begin
      fill_const(0);
      stim[p][0] = (p % 2 == 0) ? 1 : -3;
      step(1, 1, "R9");
    end
    // R4: flat raw inputs
    fill_const(5);    step(1, 1, "R4");
    fill_const(-128); step(1, 1, "R4");
    fill_const(127);  step(1, 1, "R4");
    // R1: raw mode with junk in the upper channels
    for (int i = 0; i < 6; i++) begin
      fill_rand(0);
      step(1, 1, "R1");
    end
    // R2: fully encoded inputs
    for (int i = 0; i < 20; i++) begin
      fill_rand(0);
      step(1, 0, "R2");
    end
    // R8: extreme encoded inputs
    fill_const(127);  step(1, 0, "R8");
    fill_const(-128); step(1, 0, "R8");
    for (int n = 0; n < NPT; n++)
      for (int ch = 0; ch < NCH; ch++) stim[n][ch] = (n % 2 == 0) ? 127 : -128;
    step(1, 0, "R8");
    for (int n = 0; n < NPT; n++)
      for (int ch = 0; ch < NCH; ch++) stim[n][ch] = (n == 0 || n == 7 || n == 1) ? 127 : -128;
    step(1, 0, "R8");
    for (int i = 0; i < 30; i++) begin
      fill_rand(1);
      step(1, 0, "R8");
    end
    // R6: gaps in the valid stream
    for (int i = 0; i < 12; i++) begin
      fill_rand(0);
      step((i % 3) != 0, i % 2, "R6");
    end
    fill_const(0);
    repeat (3) step(0, 1, "R6");
    // R7: asynchronous reset mid-stream
    fill_rand(0);
    step(1, 1, "R7");
    step(1, 1, "R7");
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7", "out_valid after async reset", out_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule